// File: doc/BRIEF.md
# Reference pulse holdover regenerator

This block rebuilds a slow reference pulse train, typically around 100 Hz, inside a much faster local clock domain. The raw reference is first synchronized and edge-detected. The time between rising edges is then counted in local clock cycles, and a filtered estimate of the reference period is learned from those counts. A local period counter produces a 50 % duty square wave from that estimate. While the reference is present, every accepted reference edge restarts the counter, so the copy cannot drift away from the master.

When reference edges stop arriving, the output keeps toggling at the learned period and the block raises a holdover flag. The changeover adds no extra edge to the output. When the reference comes back, the block does not jump to the new phase. It measures the phase error and bends each regenerated period by a small bounded amount until the error has been removed. Only then does it raise the lock flag again. Downstream logic can keep its timers running on the regenerated pulse through short outages of the master.

Top module: `refhold_regen`

## Requirements
- R1: A rising edge on `ref_in` is seen by the measurement and output logic after a two-flop synchronizer and an edge detector. While locked, an output restart forced by a reference edge makes `pulse_out` rise on the third rising clock edge after `ref_in` rises.
- R2: The period estimate is set to the first measured interval. After that it is updated on each accepted interval as period = period + floor((measured − period) / 8), with the arithmetic done signed. The measured interval is the number of clock cycles between two synchronized rising edges.
- R3: After reset, `pulse_out` stays low and `lock_out` stays clear until two full intervals have been measured. The output starts and `lock_out` rises at the next reference edge after that, which is the fourth edge after reset.
- R4: While locked, each reference edge restarts the output period. `pulse_out` is high 20 cycles after the edge and low 175 cycles after the edge for a learned period of 320 cycles.
- R5: The output is high for period/2 cycles (integer halving) from counter zero and low for the rest of each output period.
- R6: If no reference edge arrives before the count since the last edge reaches period + period/2, `hold_out` rises and `lock_out` falls.
- R7: In holdover, the output keeps running with an output period equal to the learned period. No high or low phase becomes a runt during entry into holdover or during reacquisition.
- R8: On the first reference edge after a loss, `hold_out` falls and `lock_out` stays clear. During reacquisition, each output period differs from the learned period by at most max(period/64, 1) cycles.
- R9: `lock_out` is reasserted only after four consecutive reference edges at which the measured phase error is within ±2 cycles.
- R10: Synchronous reset clears `pulse_out`, `lock_out` and `hold_out` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Raw reference pulse train, asynchronous to clk |
| pulse_out | output | 1 | Regenerated 50 % duty pulse train |
| lock_out | output | 1 | Output is aligned to the reference |
| hold_out | output | 1 | Reference lost; output free-running at learned rate |

## Verification
A wrong period estimate shows up within one output period after holdover begins, as an output period or high time that differs from the value restated from the edge gaps. It also shows in the moment the holdover flag rises, which is 1.5 estimated periods after the last edge. A broken synchronizer or restart path moves the output rising edge away from the third clock after each reference edge, and this is visible at the very next edge. A mistake in the phase-error sign or the slew clamp either breaks the per-period slew bound during reacquisition or keeps the lock flag from returning within a few dozen periods.

// File: rtl/refhold_pkg.sv
package refhold_pkg;

  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_LOCK  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_REACQ = 2'd3
  } rh_state_e;

  // Arithmetic is done at a fixed 32-bit width; counters must be narrower.
  typedef logic [31:0]        rh_word_t;
  typedef logic signed [33:0] rh_err_t;

  // First-order period filter: p + floor((m - p) / 8).
  function automatic rh_word_t rh_filter(rh_word_t p, rh_word_t m);
    rh_err_t d;
    d = $signed({2'b00, m}) - $signed({2'b00, p});
    d = d >>> 3;
    return 32'($signed({2'b00, p}) + d);
  endfunction

  // Count value at which the reference is declared lost.
  function automatic rh_word_t rh_loss_limit(rh_word_t p);
    return p + (p >> 1);
  endfunction

  // Largest per-period length change during reacquisition.
  function automatic rh_word_t rh_step(rh_word_t p);
    rh_word_t s;
    s = p >> 6;
    return (s == 32'd0) ? 32'd1 : s;
  endfunction

  // Signed correction still needed when a reference edge is seen.
  // Positive: lengthen output periods; negative: shorten them.
  function automatic rh_err_t rh_phase_err(rh_word_t ocnt, rh_word_t len, rh_word_t p);
    rh_word_t d;
    d = len - 32'd1 - ocnt;
    if (d <= (p >> 1)) return -$signed({2'b00, d});
    else               return $signed({2'b00, p}) - $signed({2'b00, d});
  endfunction

  function automatic rh_err_t rh_clamp(rh_err_t e, rh_err_t s);
    if (e > s)  return s;
    if (e < -s) return -s;
    return e;
  endfunction

endpackage

// File: rtl/rh_edge_sync.sv
module rh_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], raw_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R1: a detected edge is a single-cycle event
  p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/rh_period_meter.sv
module rh_period_meter
  import refhold_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic [CNT_W-1:0] period,
  output logic             trained,
  output logic             loss_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] icnt;
  logic [CNT_W-1:0] meas;
  logic [CNT_W-1:0] filt;
  logic [1:0]       nint;
  logic             have_edge;
  logic             lost;
  rh_word_t         limit;

  assign meas     = icnt + 1'b1;
  assign filt     = CNT_W'(rh_filter(32'(period), 32'(meas)));
  assign limit    = rh_loss_limit(32'(period));
  assign trained  = (nint == 2'd2);
  assign loss_evt = trained && !lost && !rise && (32'(icnt) == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt      <= '0;
      period    <= '0;
      nint      <= 2'd0;
      have_edge <= 1'b0;
      lost      <= 1'b0;
    end else if (rise) begin
      icnt      <= '0;
      have_edge <= 1'b1;
      if (lost) begin
        lost <= 1'b0;           // gap spanning the outage is not a valid interval
      end else if (have_edge) begin
        period <= (nint == 2'd0) ? meas : filt;
        if (nint != 2'd2) nint <= nint + 2'd1;
      end
    end else begin
      if (icnt != CNT_MAX) icnt <= icnt + 1'b1;
      if (loss_evt) lost <= 1'b1;
    end
  end

  // R2: a filtered update lands between the old estimate and the measurement
  p_filter_between_r2: assert property (@(posedge clk) disable iff (rst)
    (rise && have_edge && !lost && nint != 2'd0) |=>
      (($past(meas) >= $past(period)) ?
         (period >= $past(period) && period <= $past(meas)) :
         (period <= $past(period) && period >= $past(meas))));

  // R6: a timeout is reported once, then the meter waits for an edge
  p_loss_once_r6: assert property (@(posedge clk) disable iff (rst)
    loss_evt |=> !loss_evt);

endmodule

// File: rtl/rh_phase_gen.sv
module rh_phase_gen
  import refhold_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int LOCK_TOL = 2,
  parameter int GOOD_N   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             trained,
  input  logic             loss_evt,
  input  logic [CNT_W-1:0] period,
  output logic             pulse,
  output logic             lock,
  output logic             hold
);
  localparam int GW = $clog2(GOOD_N) + 1;
  localparam rh_err_t TOL = rh_err_t'(LOCK_TOL);

  rh_state_e        state, nxt_state;
  logic [CNT_W-1:0] ocnt, nxt_ocnt;
  logic [CNT_W-1:0] cur_len, nxt_len;
  logic [CNT_W-1:0] slewed_len;
  logic [CNT_W-1:0] half;
  rh_err_t          err_rem, nxt_err;
  rh_err_t          perr, apply, step_s, slew_sum;
  rh_word_t         step_w;
  logic [GW-1:0]    good, nxt_good;
  logic             wrap;
  logic             small_err;

  assign wrap       = (ocnt == cur_len - 1'b1);
  assign half       = period >> 1;
  assign perr       = rh_phase_err(32'(ocnt), 32'(cur_len), 32'(period));
  assign small_err  = (perr >= -TOL) && (perr <= TOL);
  assign step_w     = rh_step(32'(period));
  assign step_s     = $signed({2'b00, step_w});
  assign apply      = rh_clamp(err_rem, step_s);
  assign slew_sum   = $signed({2'b00, 32'(period)}) + apply;
  assign slewed_len = CNT_W'(slew_sum);

  always_comb begin
    nxt_state = state;
    nxt_err   = err_rem;
    nxt_good  = good;
    if (wrap) begin
      nxt_ocnt = '0;
      nxt_len  = (state == ST_REACQ) ? slewed_len : period;
    end else begin
      nxt_ocnt = ocnt + 1'b1;
      nxt_len  = cur_len;
    end
    case (state)
      ST_ACQ: begin
        nxt_ocnt = '0;
        nxt_len  = period;
        if (rise && trained) nxt_state = ST_LOCK;
      end
      ST_LOCK: begin
        if (loss_evt) begin
          nxt_state = ST_HOLD;
        end else if (rise) begin
          nxt_ocnt = '0;
          nxt_len  = period;
        end
      end
      ST_HOLD: begin
        if (rise) begin
          nxt_state = ST_REACQ;
          nxt_err   = perr;
          nxt_good  = small_err ? GW'(1) : '0;
        end
      end
      default: begin  // ST_REACQ
        if (wrap) nxt_err = err_rem - apply;
        if (loss_evt) begin
          nxt_state = ST_HOLD;
          nxt_good  = '0;
        end else if (rise) begin
          nxt_err = perr - (wrap ? apply : '0);
          if (!small_err) begin
            nxt_good = '0;
          end else if (good == GW'(GOOD_N - 1)) begin
            nxt_state = ST_LOCK;
            nxt_good  = '0;
            nxt_ocnt  = '0;
            nxt_len   = period;
          end else begin
            nxt_good = good + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_ACQ;
      ocnt    <= '0;
      cur_len <= '1;
      err_rem <= '0;
      good    <= '0;
      pulse   <= 1'b0;
    end else begin
      state   <= nxt_state;
      ocnt    <= nxt_ocnt;
      cur_len <= nxt_len;
      err_rem <= nxt_err;
      good    <= nxt_good;
      pulse   <= (nxt_state != ST_ACQ) && (nxt_ocnt < half);
    end
  end

  assign lock = (state == ST_LOCK);
  assign hold = (state == ST_HOLD);

  // R3: no output before the meter has two intervals
  p_dark_untrained_r3: assert property (@(posedge clk) disable iff (rst)
    !trained |-> !pulse);

  // R4: a reference edge while locked restarts the output high
  p_align_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && rise && !loss_evt) |=> (pulse && ocnt == '0));

  // R5: the output only rises at counter zero
  p_rise_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> (ocnt == '0));

  // R6: a timeout while tracking enters holdover
  p_loss_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_LOCK || state == ST_REACQ) && loss_evt) |=> hold);

  // R8: slewed period stays within one step of the learned period
  p_slew_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REACQ && wrap) |=>
      (32'(cur_len) <= 32'($past(period)) + $past(step_w) &&
       32'(cur_len) + $past(step_w) >= 32'($past(period))));

  // R9: lock is regained only from reacquisition on a reference edge
  p_relock_edge_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(lock) && $past(state) != ST_ACQ) |-> $past(rise && small_err));

endmodule

// File: rtl/refhold_regen.sv
module refhold_regen #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_TOL    = 2,
  parameter int GOOD_N      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic pulse_out,
  output logic lock_out,
  output logic hold_out
);
  logic             ref_rise;
  logic             trained;
  logic             loss_evt;
  logic [CNT_W-1:0] period;

  rh_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_in (ref_in),
    .rise   (ref_rise)
  );

  rh_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .rise     (ref_rise),
    .period   (period),
    .trained  (trained),
    .loss_evt (loss_evt)
  );

  rh_phase_gen #(
    .CNT_W    (CNT_W),
    .LOCK_TOL (LOCK_TOL),
    .GOOD_N   (GOOD_N)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .rise     (ref_rise),
    .trained  (trained),
    .loss_evt (loss_evt),
    .period   (period),
    .pulse    (pulse_out),
    .lock     (lock_out),
    .hold     (hold_out)
  );

  // R10: flags are cleared right after reset
  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (!pulse_out && !lock_out && !hold_out));

endmodule

// File: tb/refhold_regen_tb.sv
module refhold_regen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NROWS      = 12;
  localparam int GAPS[NROWS]     = '{320,320,320,320,324,316,330,320,320,320,320,320};
  localparam bit EXP_LOCK[NROWS] = '{0,0,0,1,1,1,1,1,1,1,1,1};
  localparam bit CHK_LAT[NROWS]  = '{0,0,0,1,1,0,1,0,0,0,1,1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic pulse_out, lock_out, hold_out;

  int checks = 0;
  int failures = 0;

  refhold_regen dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in),
    .pulse_out(pulse_out), .lock_out(lock_out), .hold_out(hold_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // independent model of the period estimate
  int m_p = 0, m_nint = 0, m_edges = 0, m_prev_gap = 0;
  bit m_skip = 0;

  function automatic int floor_div8(int d);
    if (d >= 0) return d / 8;
    return -((-d + 7) / 8);
  endfunction

  function automatic int max_step(int p);
    return (p / 64 > 0) ? p / 64 : 1;
  endfunction

  task automatic model_edge();
    if (m_edges > 0 && !m_skip) begin
      if (m_nint == 0) m_p = m_prev_gap;
      else             m_p = m_p + floor_div8(m_prev_gap - m_p);
      m_nint++;
    end
    m_skip = 0;
    m_edges++;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // output monitor: periods, high/low widths, slew bound
  int cyc = 0, last_rise = -1, last_per = 0, rise_cnt = 0;
  int last_edge_cyc = 0, last_hi = 0, last_lo = 0;
  int min_hi = 1 << 30, min_lo = 1 << 30;
  bit prev_p = 0, seen_edge = 0, wmon = 0, reacq_mon = 0;
  int slew_bad = 0;

  always @(negedge clk) begin
    cyc++;
    if (pulse_out != prev_p) begin
      if (seen_edge && wmon) begin
        if (prev_p) begin last_hi = cyc - last_edge_cyc; if (last_hi < min_hi) min_hi = last_hi; end
        else        begin last_lo = cyc - last_edge_cyc; if (last_lo < min_lo) min_lo = last_lo; end
      end
      seen_edge = wmon;
      last_edge_cyc = cyc;
      if (pulse_out) begin
        if (last_rise >= 0) begin
          last_per = cyc - last_rise;
          if (reacq_mon && (last_per > m_p + max_step(m_p) || last_per < m_p - max_step(m_p)))
            slew_bad++;
        end
        last_rise = cyc;
        rise_cnt++;
      end
    end
    prev_p = pulse_out;
    if (lock_out) reacq_mon = 0;
  end

  // one reference edge followed by gap cycles; samples at fixed offsets
  bit s_c1, s_c2, s_c20, s_c175, s_l20, s_h20;
  task automatic edge_run(input int gap);
    model_edge();
    ref_in = 1'b1;
    for (int c = 0; c < gap; c++) begin
      @(negedge clk);
      if (c == 7)   ref_in = 1'b0;
      if (c == 1)   s_c1 = pulse_out;
      if (c == 2)   s_c2 = pulse_out;
      if (c == 20)  begin s_c20 = pulse_out; s_l20 = lock_out; s_h20 = hold_out; end
      if (c == 175) s_c175 = pulse_out;
    end
    m_prev_gap = gap;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int lim, rc, p_hold;
    bit got_lock;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset pulse", pulse_out, 0);
    chk("R10 reset lock", lock_out, 0);
    chk("R10 reset hold", hold_out, 0);

    // table walk: training, locked tracking with edge jitter
    for (int r = 0; r < NROWS; r++) begin
      edge_run(GAPS[r]);
      chk($sformatf("R3 lock row%0d", r), s_l20, EXP_LOCK[r]);
      chk($sformatf("R6 hold row%0d", r), s_h20, 0);
      if (EXP_LOCK[r]) begin
        chk($sformatf("R4 high row%0d", r), s_c20, 1);
        chk($sformatf("R4 low row%0d", r), s_c175, 0);
        wmon = 1;
      end else begin
        chk($sformatf("R3 dark row%0d", r), s_c20, 0);
      end
      if (CHK_LAT[r]) begin
        chk($sformatf("R1 latency c1 row%0d", r), s_c1, 0);
        chk($sformatf("R1 latency c2 row%0d", r), s_c2, 1);
      end
    end

    // reference stops: loss timing and holdover free-run
    lim = m_p + m_p / 2;
    p_hold = m_p;
    repeat (lim - 15 - GAPS[NROWS-1]) @(negedge clk);
    chk("R6 hold before timeout", hold_out, 0);
    chk("R6 lock before timeout", lock_out, 1);
    repeat (30) @(negedge clk);
    chk("R6 hold after timeout", hold_out, 1);
    chk("R6 lock after timeout", lock_out, 0);
    rc = rise_cnt;
    while (rise_cnt < rc + 4) @(negedge clk);
    chk("R7 R2 holdover period", last_per, p_hold);
    chk("R5 high time", last_hi, p_hold / 2);
    chk("R5 low time", last_lo, p_hold - p_hold / 2);
    chk("R7 hold persists", hold_out, 1);

    // reference returns off-phase
    rc = rise_cnt;
    while (rise_cnt == rc) @(negedge clk);
    repeat (127) @(negedge clk);
    m_skip = 1;
    reacq_mon = 1;
    edge_run(320);
    chk("R8 hold clears on return", s_h20, 0);
    chk("R8 no lock on return", s_l20, 0);
    for (int k = 0; k < 3; k++) edge_run(320);
    chk("R9 not yet locked", s_l20, 0);
    got_lock = 0;
    for (int k = 0; k < 60 && !got_lock; k++) begin
      edge_run(320);
      if (lock_out) got_lock = 1;
    end
    chk("R9 relock reached", got_lock, 1);
    chk("R8 slew bound violations", slew_bad, 0);
    edge_run(320);
    edge_run(320);
    chk("R4 aligned high after relock", s_c20, 1);
    chk("R4 aligned low after relock", s_c175, 0);
    chk("R7 no runt high", (min_hi >= p_hold / 2 - 8) ? 1 : 0, 1);
    chk("R7 no runt low", (min_lo >= p_hold / 2 - 12) ? 1 : 0, 1);

    // mid-run reset
    wmon = 0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears lock", lock_out, 0);
    chk("R10 reset clears pulse", pulse_out, 0);
    chk("R10 reset clears hold", hold_out, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rc = rise_cnt;
    repeat (1000) @(negedge clk);
    chk("R3 dark without reference", rise_cnt - rc, 0);
    chk("R3 no lock without reference", lock_out, 0);

    summary();
    $finish;
  end
endmodule